// File: doc/BRIEF.md
# Configurable Serial Audio Output Formatter

This block turns parallel stereo sample words into a serial audio stream. A stereo frame lasts 64 bit-clock periods: the left channel takes the first 32 slots and the right channel the last 32. The word clock runs at the frame rate. A producer presents a left/right pair and pulses a strobe. The block holds that pair until the next frame begins, then shifts both words out MSB first. A strobe during a frame therefore never mixes two samples inside one word.

Two static selects choose the layout. A 2-bit format code picks left-justified, right-justified or one-bit-delayed (I2S-style) placement. A 2-bit length code picks the right-justified data length. Two polarity bits invert the bit-clock pin and the word-clock pin. In master mode the block divides its system clock to make both serial clocks and a frame sync pulse. In slave mode it takes both clocks from pins, samples them into the system clock domain, and aligns each frame to the word-clock transition.

All logic runs on one system clock. Data is launched on the falling edge of the non-inverted bit clock, so a receiver captures it on the rising edge.

Top module: `audio_ser_fmt`

## Requirements
- R1: In master mode the bit clock has a period of 2*HALF_DIV system clocks. A frame is 64 bit periods, with left in slots 0-31 and right in slots 32-63. With word-clock polarity 0 the word clock is high for left and low for right. It changes together with the launch edge that starts slot 0 or slot 32.
- R2: Serial data changes only on a launch edge, which is the falling edge of the non-inverted bit clock. Each word is sent MSB first and is stable at the following rising edge.
- R3: Format code 00 (left-justified) places sample bits 23..0 in channel slots 0..23 and drives slots 24..31 low. Code 11 behaves exactly like 00. Both ignore the length code.
- R4: Format code 10 (I2S-style) drives channel slot 0 low, places bits 23..0 in slots 1..24 and drives slots 25..31 low. It ignores the length code.
- R5: Format code 01 is right-justified, with length L chosen by the length code: 00 gives 24, 01 gives 20, 10 gives 18 and 11 gives 16. The L most significant sample bits occupy the last L slots of each channel half and end at slot 31. The leading slots are low and the remaining LSBs are dropped.
- R6: With bit-clock polarity 1 the bit-clock pin is the complement. Data then changes on its rising edge and is captured on its falling edge.
- R7: With word-clock polarity 1 the word-clock pin is low while the left channel is sent.
- R8: A strobe stores the pair. The pair stored last before a frame begins is sent for that whole frame. Strobes during a frame, even several of them, affect only later frames.
- R9: The format and length codes are taken at the start of each frame and hold for that frame.
- R10: In master mode the sync output is high for exactly the slot-0 bit period of each frame.
- R11: In slave mode the bit-clock, word-clock and sync outputs are held low. Data follows the external clocks, and a word-clock transition to the left level restarts the frame at slot 0 wherever the slot count stands.
- R12: During reset in master mode, serial data and sync are low, the bit-clock pin equals its polarity bit and the word-clock pin equals its polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | 1: serial clocks come from pins |
| fmt_sel | input | 2 | Frame format code |
| wlen_sel | input | 2 | Right-justified length code |
| bck_inv | input | 1 | Bit-clock polarity |
| wck_inv | input | 1 | Word-clock polarity |
| smp_left | input | DATA_W | Left sample word |
| smp_right | input | DATA_W | Right sample word |
| smp_stb | input | 1 | One-cycle sample-pair strobe |
| bck_in | input | 1 | External bit clock (slave) |
| wck_in | input | 1 | External word clock (slave) |
| sdo | output | 1 | Serial data |
| bck_out | output | 1 | Generated bit clock (master) |
| wck_out | output | 1 | Generated word clock (master) |
| sync_out | output | 1 | Frame sync pulse (master) |

## Verification
The assertions assume that mode and both polarity bits change only while reset is asserted. They also assume that in slave mode each half period of the external clocks lasts several system clocks, so a sampled edge is never missed. Finally, they assume that the word clock moves only together with a bit-clock launch edge. The bench applies mode and polarity only inside its reset task and runs its slave clocks at 8 system clocks per half period. It moves its word clock only on its own launch edge, including the deliberate early restart.

// File: rtl/saf_pkg.sv
`timescale 1ns/1ps
package saf_pkg;

   typedef enum logic [1:0] {
      FMT_LEFT  = 2'b00,
      FMT_RIGHT = 2'b01,
      FMT_I2S   = 2'b10,
      FMT_RSVD  = 2'b11
   } fmt_e;

   // right-justified data length for a length code
   function automatic int rj_len(input int dw, input logic [1:0] code);
      case (code)
         2'b00:   return dw;
         2'b01:   return dw - 4;
         2'b10:   return dw - 6;
         default: return dw - 8;
      endcase
   endfunction

endpackage

// File: rtl/saf_master_clk.sv
`timescale 1ns/1ps
module saf_master_clk #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic bck_lvl,
   output logic launch
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

   if (HALF_DIV < 2) begin : g_bad_div
      $error("HALF_DIV must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt     <= '0;
         bck_lvl <= 1'b0;
      end else if (cnt == LAST) begin
         cnt     <= '0;
         bck_lvl <= ~bck_lvl;
      end else begin
         cnt <= cnt + CW'(1);
      end
   end

   // launch marks the cycle whose edge drops the bit clock
   assign launch = en && (cnt == LAST) && bck_lvl;

endmodule

// File: rtl/saf_slave_edge.sv
`timescale 1ns/1ps
module saf_slave_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic bck_pin,
   input  logic wck_pin,
   input  logic bck_inv,
   input  logic wck_inv,
   output logic launch,
   output logic frame_mark
);
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] bs, ws;

   if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bs <= '0;
            ws <= '0;
         end else begin
            bs <= bck_pin;
            ws <= wck_pin;
         end
      end
   end else begin : g_syncn
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bs <= '0;
            ws <= '0;
         end else begin
            bs <= {bs[SYNC_STAGES-2:0], bck_pin};
            ws <= {ws[SYNC_STAGES-2:0], wck_pin};
         end
      end
   end

   logic nb, nw, nb_q, nw_at_launch;
   assign nb = bs[SYNC_STAGES-1] ^ bck_inv;
   assign nw = ws[SYNC_STAGES-1] ^ wck_inv;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nb_q         <= 1'b0;
         nw_at_launch <= 1'b1;
      end else begin
         nb_q <= nb;
         if (launch) nw_at_launch <= nw;
      end
   end

   assign launch     = en && nb_q && !nb;
   assign frame_mark = launch && nw && !nw_at_launch;

endmodule

// File: rtl/saf_shifter.sv
`timescale 1ns/1ps
module saf_shifter
   import saf_pkg::*;
#(
   parameter int DATA_W   = 24,
   parameter int CH_SLOTS = 32,
   parameter int SLOT_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [SLOT_W-1:0] next_slot,
   input  logic [DATA_W-1:0] smp_left,
   input  logic [DATA_W-1:0] smp_right,
   input  logic              smp_stb,
   input  logic [1:0]        fmt_sel,
   input  logic [1:0]        wlen_sel,
   output logic              sdo
);
   localparam int IW = $clog2(DATA_W);

   logic [DATA_W-1:0] pend_l, pend_r, act_l, act_r;
   fmt_e              act_fmt;
   logic [1:0]        act_wl;
   logic              frame_go;

   assign frame_go = launch && (next_slot == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_l  <= '0;
         pend_r  <= '0;
         act_l   <= '0;
         act_r   <= '0;
         act_fmt <= FMT_LEFT;
         act_wl  <= 2'b00;
      end else begin
         if (smp_stb) begin
            pend_l <= smp_left;
            pend_r <= smp_right;
         end
         if (frame_go) begin
            act_l   <= pend_l;
            act_r   <= pend_r;
            act_fmt <= fmt_e'(fmt_sel);
            act_wl  <= wlen_sel;
         end
      end
   end

   fmt_e              cur_fmt;
   logic [1:0]        cur_wl;
   logic [DATA_W-1:0] word;
   int                pos, len, first;
   logic              bit_n;

   always_comb begin
      cur_fmt = frame_go ? fmt_e'(fmt_sel) : act_fmt;
      cur_wl  = frame_go ? wlen_sel : act_wl;
      if (next_slot[SLOT_W-1]) word = frame_go ? pend_r : act_r;
      else                     word = frame_go ? pend_l : act_l;
      pos   = int'(next_slot[SLOT_W-2:0]);
      len   = rj_len(DATA_W, cur_wl);
      first = CH_SLOTS - len;
      bit_n = 1'b0;
      case (cur_fmt)
         FMT_I2S:   if (pos >= 1 && pos <= DATA_W) bit_n = word[IW'(DATA_W - pos)];
         FMT_RIGHT: if (pos >= first) bit_n = word[IW'(DATA_W - 1 - (pos - first))];
         default:   if (pos < DATA_W) bit_n = word[IW'(DATA_W - 1 - pos)];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      sdo <= 1'b0;
      else if (launch) sdo <= bit_n;
   end

   // R2: serial data only moves after a launch edge
   a_r2_sdo_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdo) |-> $past(launch));

   // R8: the sent pair holds between frame starts
   a_r8_hold_pair: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_go |=> ($stable(act_l) && $stable(act_r)));

   // R4: I2S-style lead slot is low
   a_r4_i2s_lead: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && cur_fmt == FMT_I2S && pos == 0) |=> !sdo);

   // R3: left-justified tail slots are low
   a_r3_lj_tail: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && cur_fmt == FMT_LEFT && pos >= DATA_W) |=> !sdo);

endmodule

// File: rtl/audio_ser_fmt.sv
`timescale 1ns/1ps
module audio_ser_fmt #(
   parameter int DATA_W      = 24,
   parameter int CH_SLOTS    = 32,
   parameter int HALF_DIV    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slave_mode,
   input  logic [1:0]        fmt_sel,
   input  logic [1:0]        wlen_sel,
   input  logic              bck_inv,
   input  logic              wck_inv,
   input  logic [DATA_W-1:0] smp_left,
   input  logic [DATA_W-1:0] smp_right,
   input  logic              smp_stb,
   input  logic              bck_in,
   input  logic              wck_in,
   output logic              sdo,
   output logic              bck_out,
   output logic              wck_out,
   output logic              sync_out
);
   localparam int SLOT_W = $clog2(2 * CH_SLOTS);

   if ((CH_SLOTS & (CH_SLOTS - 1)) != 0) begin : g_bad_slots
      $error("CH_SLOTS must be a power of two");
   end
   if (DATA_W + 1 > CH_SLOTS || DATA_W < 9) begin : g_bad_width
      $error("DATA_W must lie in 9..CH_SLOTS-1");
   end

   logic m_lvl, m_launch, s_launch, s_mark, launch, restart;
   logic [SLOT_W-1:0] slot, next_slot;

   saf_master_clk #(.HALF_DIV(HALF_DIV)) u_mclk (
      .clk(clk), .rst_n(rst_n), .en(!slave_mode),
      .bck_lvl(m_lvl), .launch(m_launch)
   );

   saf_slave_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sedge (
      .clk(clk), .rst_n(rst_n), .en(slave_mode),
      .bck_pin(bck_in), .wck_pin(wck_in),
      .bck_inv(bck_inv), .wck_inv(wck_inv),
      .launch(s_launch), .frame_mark(s_mark)
   );

   assign launch    = slave_mode ? s_launch : m_launch;
   assign restart   = slave_mode && s_mark;
   assign next_slot = restart ? '0 : slot + SLOT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)      slot <= '1;
      else if (launch) slot <= next_slot;
   end

   saf_shifter #(.DATA_W(DATA_W), .CH_SLOTS(CH_SLOTS), .SLOT_W(SLOT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .launch(launch), .next_slot(next_slot),
      .smp_left(smp_left), .smp_right(smp_right), .smp_stb(smp_stb),
      .fmt_sel(fmt_sel), .wlen_sel(wlen_sel), .sdo(sdo)
   );

   assign bck_out  = slave_mode ? 1'b0 : (m_lvl ^ bck_inv);
   assign wck_out  = slave_mode ? 1'b0 : (~slot[SLOT_W-1] ^ wck_inv);
   assign sync_out = !slave_mode && (slot == '0);

   // R1: master slot count steps by one per launch
   a_r1_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave_mode && launch) |=> (slot == $past(slot) + SLOT_W'(1)));

   // R11: slave mode keeps clock and sync outputs quiet
   a_r11_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      slave_mode |-> (!bck_out && !wck_out && !sync_out));

   // R10: sync only appears while the left channel is on the word clock
   a_r10_sync_left: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave_mode && sync_out) |-> (wck_out != wck_inv));

endmodule

// File: tb/tb_audio_ser_fmt.sv
`timescale 1ns/1ps
module tb_audio_ser_fmt;
   localparam int DW = 24, CHS = 32, HALF = 4, SLV_HALF = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0, slave_mode = 1'b0, bck_inv = 1'b0, wck_inv = 1'b0;
   logic [1:0] fmt_sel = 2'b00, wlen_sel = 2'b00;
   logic [DW-1:0] smp_left = '0, smp_right = '0;
   logic smp_stb = 1'b0, bck_in = 1'b0, wck_in = 1'b0;
   logic sdo, bck_out, wck_out, sync_out;

   audio_ser_fmt #(.DATA_W(DW), .CH_SLOTS(CHS), .HALF_DIV(HALF), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .fmt_sel(fmt_sel),
      .wlen_sel(wlen_sel), .bck_inv(bck_inv), .wck_inv(wck_inv),
      .smp_left(smp_left), .smp_right(smp_right), .smp_stb(smp_stb),
      .bck_in(bck_in), .wck_in(wck_in), .sdo(sdo), .bck_out(bck_out),
      .wck_out(wck_out), .sync_out(sync_out)
   );

   int checks = 0, errors = 0;

   typedef struct {
      logic [DW-1:0] l, r;
      logic [1:0]    f, w;
      int            fr;
      string         tag;
   } item_t;
   item_t q[$];

   int frames = 0, bidx = 0, last_fr = 0;
   bit active = 0;
   bit slave_run = 0, realign_req = 0;

   task automatic check(input bit ok, input string tag, input logic [63:0] act, exp, input string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // model of one channel slot, from R3/R4/R5
   function automatic logic exp_bit(input logic [DW-1:0] w, input logic [1:0] f, wl, input int p);
      int len;
      case (f)
         2'b10: return (p >= 1 && p <= DW) ? w[DW-p] : 1'b0;
         2'b01: begin
            len = (wl == 2'b00) ? DW : (wl == 2'b01) ? DW-4 : (wl == 2'b10) ? DW-6 : DW-8;
            return (p >= CHS-len) ? w[DW-1-(p-(CHS-len))] : 1'b0;
         end
         default: return (p < DW) ? w[DW-1-p] : 1'b0;
      endcase
   endfunction

   // slave clock source: launch on normalized falling edge
   initial begin
      int sdiv = 0, bslot = 63;
      bit snb = 0;
      forever begin
         @(posedge clk); #1;
         if (!slave_run) begin
            sdiv = 0; snb = 0; bslot = 63;
         end else begin
            sdiv++;
            if (sdiv == SLV_HALF) begin
               sdiv = 0;
               if (snb) begin
                  snb = 0;
                  bslot = (bslot + 1) % 64;
                  if (realign_req && bslot >= 40) begin bslot = 0; realign_req = 0; end
               end else snb = 1;
            end
         end
         bck_in = snb ^ bck_inv;
         wck_in = (bslot < 32) ^ wck_inv;
      end
   end

   // monitor: capture each frame on receive edges and compare to scoreboard
   initial begin
      logic [63:0] got, expv;
      bit prev_b = 0, prev_w = 0, nb, nw, found;
      item_t it;
      forever begin
         @(posedge clk); #2;
         if (!rst_n) begin
            prev_b = 0; prev_w = 0; frames = 0; active = 0; bidx = 0;
            continue;
         end
         nb = (slave_mode ? bck_in : bck_out) ^ bck_inv;
         nw = (slave_mode ? wck_in : wck_out) ^ wck_inv;
         if (nb && !prev_b) begin
            if (nw && !prev_w) begin frames++; bidx = 0; active = 1; end
            if (active) begin
               if (!slave_mode && bidx == 0)
                  check(sync_out === 1'b1, "R10", {63'b0, sync_out}, 64'd1, "sync at slot 0");
               if (!slave_mode && bidx == 1)
                  check(sync_out === 1'b0, "R10", {63'b0, sync_out}, 64'd0, "sync at slot 1");
               got[bidx] = sdo;
               bidx++;
               if (bidx == 2*CHS) begin
                  active = 0;
                  found = 0;
                  while (q.size() > 0 && q[0].fr <= frames) begin
                     if (q[0].fr == frames) begin it = q[0]; found = 1; end
                     void'(q.pop_front());
                  end
                  if (found) begin
                     for (int p = 0; p < 2*CHS; p++)
                        expv[p] = (p < CHS) ? exp_bit(it.l, it.f, it.w, p) : exp_bit(it.r, it.f, it.w, p-CHS);
                     check(got === expv, it.tag, got, expv, "frame bits (slot 0 in bit 0)");
                  end
               end
            end
            prev_w = nw;
         end
         prev_b = nb;
      end
   end

   task automatic send(input logic [DW-1:0] l, r, input logic [1:0] f, w, input bit same, input string tag);
      item_t it;
      do begin @(posedge clk); #1; end
      while (!(frames >= 1 && active && bidx >= 8 && bidx < 40 && (same || frames > last_fr)));
      fmt_sel = f; wlen_sel = w; smp_left = l; smp_right = r; smp_stb = 1'b1;
      @(posedge clk); #1;
      smp_stb = 1'b0;
      it.l = l; it.r = r; it.f = f; it.w = w; it.fr = frames + 1; it.tag = tag;
      q.push_back(it);
      last_fr = frames;
   endtask

   task automatic drain();
      int f0 = frames, cyc = 0;
      while (q.size() != 0 && frames < f0 + 4 && cyc < 20000) begin @(posedge clk); cyc++; end
      check(q.size() == 0, "R8", 64'(q.size()), 64'd0, "undelivered frames");
   endtask

   task automatic do_reset(input bit slv, bi, wi);
      rst_n = 1'b0; slave_run = 0; slave_mode = slv; bck_inv = bi; wck_inv = wi;
      fmt_sel = 2'b00; wlen_sel = 2'b00; smp_stb = 1'b0; smp_left = '0; smp_right = '0;
      q.delete(); last_fr = 0;
      repeat (4) @(posedge clk); #1;
      check(sdo === 1'b0 && sync_out === 1'b0 && bck_out === (slv ? 1'b0 : bi) && wck_out === (slv ? 1'b0 : wi),
            slv ? "R11" : "R12", {60'b0, sdo, sync_out, bck_out, wck_out},
            {62'b0, slv ? 1'b0 : bi, slv ? 1'b0 : wi}, "outputs in reset {sdo,sync,bck,wck}");
      rst_n = 1'b1; slave_run = slv;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // master, plain polarity
      do_reset(0, 0, 0);
      send(24'hA5C3E1, 24'h5A3C1E, 2'b00, 2'b00, 0, "R3 R1 R2");
      send(24'h800001, 24'h7FFFFE, 2'b00, 2'b11, 0, "R3 length ignored");
      send(24'h123456, 24'hFEDCBA, 2'b11, 2'b01, 0, "R3 code 11");
      send(24'hC00003, 24'h3FFFFC, 2'b10, 2'b01, 0, "R4");
      send(24'hF0F0F0, 24'h0F0F0F, 2'b01, 2'b00, 0, "R5 len 24");
      send(24'hABCDEF, 24'h13579B, 2'b01, 2'b01, 0, "R5 len 20 R9");
      send(24'hFFFFFF, 24'h800000, 2'b01, 2'b10, 0, "R5 len 18");
      send(24'h9ABCDE, 24'h76543F, 2'b01, 2'b11, 0, "R5 len 16");
      send(24'h111111, 24'h222222, 2'b00, 2'b00, 0, "R8 first");
      send(24'hCAFE01, 24'hBEEF02, 2'b00, 2'b00, 1, "R8 mid-frame update");
      drain();
      // bit-clock polarity inverted
      do_reset(0, 1, 0);
      send(24'h5A5A5A, 24'hA5A5A5, 2'b00, 2'b00, 0, "R6");
      send(24'h0F1E2D, 24'h3C4B5A, 2'b10, 2'b00, 0, "R6 I2S");
      drain();
      // word-clock polarity inverted, and both
      do_reset(0, 0, 1);
      send(24'h6789AB, 24'hCDEF01, 2'b00, 2'b00, 0, "R7");
      send(24'h314159, 24'h271828, 2'b01, 2'b11, 0, "R7 RJ");
      drain();
      do_reset(0, 1, 1);
      send(24'hDEAD01, 24'h00BEEF, 2'b10, 2'b00, 0, "R6 R7");
      drain();
      // slave mode
      do_reset(1, 0, 0);
      send(24'hA1B2C3, 24'hD4E5F6, 2'b00, 2'b00, 0, "R11 LJ");
      send(24'h765432, 24'h89ABCD, 2'b10, 2'b00, 0, "R11 I2S");
      send(24'hFEDCBA, 24'h012345, 2'b01, 2'b01, 0, "R11 RJ");
      drain();
      realign_req = 1;
      send(24'h55AA55, 24'hAA55AA, 2'b00, 2'b00, 0, "R11 after restart");
      send(24'h13579B, 24'h2468AC, 2'b01, 2'b10, 0, "R11 after restart RJ");
      drain();
      do_reset(1, 1, 1);
      send(24'h0C0FFE, 24'hE0FF0C, 2'b10, 2'b00, 0, "R11 inverted pins");
      drain();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule